// File: doc/BRIEF.md
# Transmit Frame Padder with CRC-32 Trailer

This block sits on the transmit side between a host byte stream and the MAC transmit path. Frames arrive one byte per beat with start, end and valid markers and leave under the same ready/valid handshake, with the same framing markers. Two enable inputs select what is added. Padding extends a short frame with zero bytes, so that the frame, including its four-byte check sequence, reaches the minimum length. CRC generation computes a CRC-32 over the frame and appends it as a trailer.

Whenever padding is enabled, the block also appends a CRC, even if CRC generation is off. Pad bytes follow the host's last byte, and the trailer follows the pad bytes. While the block emits pad or trailer bytes it holds its input ready low. The end marker on the output moves to the last trailer byte. Both enables are sampled with the first byte of each frame and hold for the whole frame.

Top module: `tx_pad_crc`

## Requirements
- R1: With both enables low at the start of a frame, each output byte equals the matching input byte with its start and end markers, and no byte is added.
- R2: With CRC generation enabled, four bytes follow the data. They are the complement of the reflected CRC-32 (polynomial 0xEDB88320, initial value all ones) over every data and pad byte, least significant byte first. The data "123456789" yields the trailer 0x26, 0x39, 0xF4, 0xCB.
- R3: With padding enabled and fewer than MIN_FRAME-4 data bytes, 0x00 bytes follow the data until there are MIN_FRAME-4 bytes, then the trailer follows. A 64-byte minimum gives a total of 64 bytes.
- R4: Padding enabled with CRC generation disabled still appends the trailer.
- R5: With padding enabled and MIN_FRAME-4 or more data bytes, no pad byte is added, and only the trailer follows.
- R6: in_ready_o is low from the acceptance of the host's last byte until the last trailer byte is accepted, whenever bytes are appended.
- R7: When bytes are appended, the host's end-marked byte leaves without the end marker. The end marker appears only on the last trailer byte, and the start marker appears only on the first byte.
- R8: While out_valid_o is high and out_ready_i is low, out_valid_o stays high and out_data_o does not change.
- R9: After reset, out_valid_o is low while no input is valid, and in_ready_o follows out_ready_i.
- R10: Changes of pad_en_i or crc_en_i after a frame's first byte do not affect that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pad_en_i | input | 1 | Enable short-frame padding (this also forces the trailer) |
| crc_en_i | input | 1 | Enable CRC-32 trailer |
| in_data_i | input | 8 | Host byte |
| in_valid_i | input | 1 | Host byte valid |
| in_sop_i | input | 1 | First byte of frame |
| in_eop_i | input | 1 | Last byte of frame |
| in_ready_o | output | 1 | Block accepts a host byte |
| out_data_o | output | 8 | Output byte |
| out_valid_o | output | 1 | Output byte valid |
| out_sop_o | output | 1 | First output byte of frame |
| out_eop_o | output | 1 | Last output byte of frame |
| out_ready_i | input | 1 | Downstream accepts a byte |

## Verification
The bench builds the block with the default MIN_FRAME of 64, so the pad target is 60 data bytes. This puts the edges of the pad decision within reach of short directed frames: 1, 10, 59, 60, 61 and 100 bytes. A pseudo-random pattern on out_ready_i stalls both pass-through bytes and pad and trailer bytes. The standard check string confirms the CRC against fixed trailer bytes, not only against the bench's own computation.

// File: rtl/tx_pad_pkg.sv
package tx_pad_pkg;
  typedef enum logic [1:0] {S_DATA, S_PAD, S_FCS} tx_state_e;

  localparam logic [31:0] CRC_INIT = 32'hFFFF_FFFF;
  localparam logic [31:0] CRC_POLY = 32'hEDB8_8320;

  function automatic logic [31:0] crc32_byte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'h0, d};
    for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    return r;
  endfunction
endpackage

// File: rtl/tx_byte_cnt.sv
module tx_byte_cnt #(
  parameter int MAX = 60,
  localparam int W = $clog2(MAX + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (clr_i)                     cnt_q <= '0;
    else if (inc_i && cnt_q != W'(MAX)) cnt_q <= cnt_q + W'(1);
  end

  assign cnt_o = cnt_q;

  a_r3_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= W'(MAX));
endmodule

// File: rtl/tx_crc_acc.sv
module tx_crc_acc
  import tx_pad_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        upd_i,
  input  logic [7:0]  byte_i,
  output logic [31:0] crc_o
);
  logic [31:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= CRC_INIT;
    else if (clr_i)  crc_q <= CRC_INIT;
    else if (upd_i)  crc_q <= crc32_byte(crc_q, byte_i);
  end

  assign crc_o = crc_q;

  a_r2_fresh_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> crc_q == CRC_INIT);
endmodule

// File: rtl/tx_pad_crc.sv
module tx_pad_crc
  import tx_pad_pkg::*;
#(
  parameter int MIN_FRAME = 64
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pad_en_i,
  input  logic       crc_en_i,
  input  logic [7:0] in_data_i,
  input  logic       in_valid_i,
  input  logic       in_sop_i,
  input  logic       in_eop_i,
  output logic       in_ready_o,
  output logic [7:0] out_data_o,
  output logic       out_valid_o,
  output logic       out_sop_o,
  output logic       out_eop_o,
  input  logic       out_ready_i
);
  localparam int FCS_BYTES = 4;
  localparam int MIN_DATA  = MIN_FRAME - FCS_BYTES;
  localparam int CNT_W     = $clog2(MIN_DATA + 1);
  localparam int IDX_W     = $clog2(FCS_BYTES);

  tx_state_e   state_q, state_d;
  logic        in_frame_q, pad_q, crc_q;
  logic        eff_pad, eff_crc, append;
  logic        data_hs, pad_hs, fcs_hs, out_hs, last_hs;
  logic [CNT_W-1:0] data_cnt;
  logic [IDX_W-1:0] fcs_idx;
  logic [31:0] crc_val, fcs;
  logic        short_now;

  // mode is frozen at the first byte of a frame
  assign eff_pad = in_frame_q ? pad_q : pad_en_i;
  assign eff_crc = in_frame_q ? crc_q : crc_en_i;
  assign append  = eff_pad | eff_crc;

  assign fcs       = ~crc_val;
  assign short_now = (int'(data_cnt) + 1) < MIN_DATA;

  always_comb begin
    in_ready_o  = 1'b0;
    out_valid_o = 1'b1;
    out_data_o  = 8'h00;
    out_sop_o   = 1'b0;
    out_eop_o   = 1'b0;
    unique case (state_q)
      S_DATA: begin
        in_ready_o  = out_ready_i;
        out_valid_o = in_valid_i;
        out_data_o  = in_data_i;
        out_sop_o   = in_sop_i;
        out_eop_o   = in_eop_i & ~append;
      end
      S_PAD: ;
      S_FCS: begin
        out_data_o = fcs[8*fcs_idx +: 8];
        out_eop_o  = (fcs_idx == IDX_W'(FCS_BYTES - 1));
      end
      default: out_valid_o = 1'b0;
    endcase
  end

  assign out_hs  = out_valid_o & out_ready_i;
  assign data_hs = out_hs & (state_q == S_DATA);
  assign pad_hs  = out_hs & (state_q == S_PAD);
  assign fcs_hs  = out_hs & (state_q == S_FCS);
  assign last_hs = out_hs & out_eop_o;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_DATA: if (data_hs && in_eop_i && append)
                state_d = (eff_pad && short_now) ? S_PAD : S_FCS;
      S_PAD:  if (pad_hs && !short_now) state_d = S_FCS;
      S_FCS:  if (last_hs) state_d = S_DATA;
      default: state_d = S_DATA;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_DATA;
      in_frame_q <= 1'b0;
      pad_q      <= 1'b0;
      crc_q      <= 1'b0;
    end else begin
      state_q <= state_d;
      if (data_hs && !in_frame_q) begin
        pad_q <= pad_en_i;
        crc_q <= crc_en_i;
      end
      if (last_hs)      in_frame_q <= 1'b0;
      else if (data_hs) in_frame_q <= 1'b1;
    end
  end

  tx_byte_cnt #(.MAX(MIN_DATA)) u_data_cnt (
    .clk_i (clk_i), .rst_ni(rst_ni), .clr_i(last_hs),
    .inc_i (data_hs | pad_hs), .cnt_o(data_cnt)
  );

  tx_byte_cnt #(.MAX(FCS_BYTES - 1)) u_fcs_idx (
    .clk_i (clk_i), .rst_ni(rst_ni), .clr_i(last_hs),
    .inc_i (fcs_hs), .cnt_o(fcs_idx)
  );

  tx_crc_acc u_crc (
    .clk_i (clk_i), .rst_ni(rst_ni), .clr_i(last_hs),
    .upd_i (data_hs | pad_hs), .byte_i(out_data_o), .crc_o(crc_val)
  );

  a_r6_no_accept_in_trailer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != S_DATA) |-> !in_ready_o);
  a_r3_pad_reaches_min: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_FCS && pad_q) |-> (int'(data_cnt) == MIN_DATA));
  a_r8_trailer_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != S_DATA && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));
  a_r7_eop_closes_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_FCS && last_hs) |=> (state_q == S_DATA && !in_frame_q));
  a_r1_bypass_no_trailer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_frame_q && !pad_q && !crc_q) |-> state_q == S_DATA);
endmodule

// File: tb/tx_pad_crc_tb_top.sv
module tx_pad_crc_tb_top;
  localparam int MIN_FRAME = 64;
  localparam int MIN_DATA  = MIN_FRAME - 4;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       pad_en_i = 1'b0, crc_en_i = 1'b0;
  logic [7:0] in_data_i = '0;
  logic       in_valid_i = 1'b0, in_sop_i = 1'b0, in_eop_i = 1'b0;
  logic       in_ready_o, out_valid_o, out_sop_o, out_eop_o;
  logic [7:0] out_data_o;
  logic       out_ready_i = 1'b1;

  int checks = 0, errors = 0, cycles = 0, bp_viol = 0, r6_viol = 0;
  bit bp_en = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic [7:0]  payload_q[$];
  logic [9:0]  got_q[$];
  logic [9:0]  exp_q[$];
  logic        prev_stall = 1'b0;
  logic [7:0]  prev_data = '0;

  always #10 clk_i = ~clk_i;

  tx_pad_crc #(.MIN_FRAME(MIN_FRAME)) dut_i (.*);

  always @(posedge clk_i) begin
    cycles <= cycles + 1;
    #1;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready_i <= bp_en ? lfsr[3] | lfsr[7] : 1'b1;
  end

  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (prev_stall && !(out_valid_o && out_data_o == prev_data)) bp_viol++;
      prev_stall = out_valid_o && !out_ready_i;
      prev_data  = out_data_o;
      if (out_valid_o && out_ready_i) got_q.push_back({out_sop_o, out_eop_o, out_data_o});
    end
  end

  always @(posedge clk_i) if (cycles > 150000) begin
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic check(input string req, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(input logic [7:0] b[$]);
    logic [31:0] c = 32'hFFFF_FFFF;
    foreach (b[i]) begin
      c ^= {24'h0, b[i]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
    end
    return ~c;
  endfunction

  task automatic fill(input int len, input int seed);
    payload_q.delete();
    for (int i = 0; i < len; i++) payload_q.push_back(8'((seed + i * 37) ^ (i >> 2)));
  endtask

  task automatic build_exp(input bit pad, input bit crc);
    logic [7:0] body[$];
    logic [31:0] f;
    body = payload_q;
    if (pad) while (body.size() < MIN_DATA) body.push_back(8'h00);
    if (pad || crc) begin
      f = ref_crc(body);
      for (int k = 0; k < 4; k++) body.push_back(f[8*k +: 8]);
    end
    exp_q.delete();
    foreach (body[i]) exp_q.push_back({i == 0, i == body.size() - 1, body[i]});
  endtask

  task automatic send(input string req, input bit pad, input bit crc, input bit bp,
                      input bit hold_next, input bit toggle);
    int n, bad_byte, bad_mark;
    bit acc;
    got_q.delete();
    build_exp(pad, crc);
    bp_en = bp;
    @(posedge clk_i); #1;
    pad_en_i = pad; crc_en_i = crc;
    foreach (payload_q[i]) begin
      in_valid_i = 1'b1; in_data_i = payload_q[i];
      in_sop_i = (i == 0); in_eop_i = (i == payload_q.size() - 1);
      do begin
        @(negedge clk_i); acc = in_ready_o;
        @(posedge clk_i); #1;
      end while (!acc);
      if (toggle && i == 0) begin pad_en_i = ~pad; crc_en_i = ~crc; end
    end
    if (hold_next) begin in_sop_i = 1'b1; in_eop_i = 1'b0; in_data_i = 8'hAA; end
    else in_valid_i = 1'b0;
    while (got_q.size() < exp_q.size()) begin
      if (hold_next && in_ready_o) r6_viol++;
      @(posedge clk_i); #1;
    end
    in_valid_i = 1'b0; in_sop_i = 1'b0; in_eop_i = 1'b0;
    bp_en = 1'b0;
    repeat (3) @(posedge clk_i);
    #1;
    n = got_q.size();
    check({req, " length"}, n == exp_q.size(), n, exp_q.size());
    bad_byte = -1; bad_mark = -1;
    for (int i = 0; i < n && i < exp_q.size(); i++) begin
      if (bad_byte < 0 && got_q[i][7:0] != exp_q[i][7:0]) bad_byte = i;
      if (bad_mark < 0 && got_q[i][9:8] != exp_q[i][9:8]) bad_mark = i;
    end
    check({req, " bytes"}, bad_byte < 0,
          bad_byte < 0 ? 0 : int'(got_q[bad_byte][7:0]), bad_byte < 0 ? 0 : int'(exp_q[bad_byte][7:0]));
    check({req, " R7 markers"}, bad_mark < 0,
          bad_mark < 0 ? 0 : int'(got_q[bad_mark][9:8]), bad_mark < 0 ? 0 : int'(exp_q[bad_mark][9:8]));
  endtask

  task automatic t_reset;
    check("R9 out_valid after reset", out_valid_o == 1'b0, out_valid_o, 0);
    check("R9 in_ready follows out_ready", in_ready_o == out_ready_i, in_ready_o, out_ready_i);
  endtask

  task automatic t_known_crc;
    logic [7:0] s[9] = '{8'h31,8'h32,8'h33,8'h34,8'h35,8'h36,8'h37,8'h38,8'h39};
    payload_q.delete();
    foreach (s[i]) payload_q.push_back(s[i]);
    send("R2 check string", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R2 fixed trailer", got_q.size() == 13 &&
          {got_q[12][7:0], got_q[11][7:0], got_q[10][7:0], got_q[9][7:0]} == 32'hCBF43926,
          got_q.size() == 13 ? {got_q[12][7:0], got_q[11][7:0], got_q[10][7:0], got_q[9][7:0]} : 0,
          32'hCBF43926);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    fill(10, 3);   send("R1 bypass",            0, 0, 0, 0, 0);
    fill(17, 9);   send("R1 R8 bypass stalled", 0, 0, 1, 0, 0);
    fill(20, 5);   send("R2 crc only",          0, 1, 0, 0, 0);
    t_known_crc();
    fill(10, 1);   send("R3 R4 pad only",       1, 0, 0, 1, 0);
    check("R6 ready low in trailer", r6_viol == 0, r6_viol, 0);
    fill(1, 77);   send("R3 pad one byte",      1, 1, 0, 0, 0);
    fill(59, 11);  send("R3 pad 59",            1, 0, 0, 0, 0);
    fill(60, 12);  send("R5 pad 60",            1, 0, 0, 0, 0);
    fill(61, 13);  send("R5 pad 61",            1, 1, 0, 0, 0);
    fill(100, 14); send("R5 crc 100",           0, 1, 1, 0, 0);
    fill(12, 21);  send("R10 toggle to on",     0, 0, 0, 0, 1);
    fill(12, 22);  send("R10 toggle to off",    1, 1, 0, 0, 1);
    fill(30, 40);  send("R8 pad stalled",       1, 0, 1, 1, 0);
    check("R8 stall holds output", bp_viol == 0, bp_viol, 0);
    check("R6 ready low stalled", r6_viol == 0, r6_viol, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule